// File: doc/BRIEF.md
# Thermal threshold interrupt monitor

This block watches a stream of 8-bit raw temperature codes, each marked by a one-cycle valid strobe. It compares every accepted code with three programmable rising levels and three programmable falling levels. Each event is recorded in its own pending flag. Software masks the flags with an enable register and clears them by writing ones. The single interrupt line is raised by any flag that is both pending and enabled.

A fourth rising level, the hardware-trip level, drives a sticky trip output. That output does not depend on the interrupt enables and is meant for a power controller. It releases only on reset.

All settings sit behind a small word-wide register port. Writes take effect on the clock edge and reads are combinational. The control register also holds a 4-bit sensor select field, which the block drives straight out to the sensor multiplexer.

Top module: `thermal_irq_monitor`

## Requirements
- R1: After reset every readable register returns zero, and `irq`, `trip_out` and `sensor_sel` are low.
- R2: Control register at address 0: bit 0 enables the core, bit 12 enables the hardware trip, and bits 23:20 select the sensor (driven on `sensor_sel`). All other bits read zero.
- R3: Rising-level register at address 1: byte 0 is level 0, byte 1 is level 1, byte 2 is level 2 and byte 3 is the hardware-trip level. Falling-level register at address 2: bytes 0 to 2 are falling levels 0 to 2, and byte 3 reads zero.
- R4: Enable register at address 3: the rising enable for level N is at bit 4N and the falling enable for level N is at bit 16+4N. All other bits read zero.
- R5: The pending bit 4N (rising, level N) sets when a valid sample, taken with the core enabled, has a code greater than or equal to rising level N. The bit is readable in the cycle after that sample.
- R6: Level N is armed by a sample that sets its rising flag. While armed, a valid sample whose code is below falling level N sets pending bit 16+4N and disarms the level, even if the same sample also meets the rising level. A disarmed level never sets its falling flag.
- R7: While the core is disabled, or while the valid strobe is low, no pending flag and no trip state changes.
- R8: Writing the clear register (address 5) clears each pending flag whose bit is one. Zero bits have no effect and the register reads zero. A flag that is set by a sample in the same cycle stays set.
- R9: The pending register at address 4 is read-only, so writes to it change nothing.
- R10: `irq` is high exactly when some pending flag has its enable bit set.
- R11: `trip_out` sets after a valid sample with the core enabled, the trip enabled, and a code at or above the hardware-trip level. It is unaffected by the interrupt enables and by clear writes, and it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_valid | input | 1 | Marks `temp_code` as a new sample |
| temp_code | input | 8 | Raw temperature code |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | OR of pending flags masked by enables |
| trip_out | output | 1 | Sticky hardware thermal trip |
| sensor_sel | output | 4 | Sensor select field of the control register |

## Verification
The checker assumes that `temp_code` and the register inputs are known whenever their strobes are high. It also assumes that a clear and a sample in the same cycle resolve in favour of the sample, so its clear property excludes a coinciding level-0 hit. The bench changes every input only on the falling clock edge. It holds each valid strobe or write strobe for exactly one rising edge, and it only uses addresses 0 to 5. Each level is therefore seen once per sample, and each write lands once.

// File: rtl/thermal_pkg.sv
// Shared constants for the thermal threshold monitor: register addresses,
// field positions and the code width. Assumes three interrupt levels packed
// one per byte, which fixes LEVELS*CODE_W to fit a word.
package thermal_pkg;
    localparam int CODE_W      = 8;
    localparam int LEVELS      = 3;
    localparam int WORD_W      = 32;
    localparam int ADDR_W      = 3;
    localparam int STRIDE      = 4;
    localparam int FALL_BASE   = 16;
    localparam int CORE_BIT    = 0;
    localparam int TRIP_EN_BIT = 12;
    localparam int MUX_LSB     = 20;
    localparam int MUX_W       = 4;
    localparam int HW_BYTE     = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_RISE = 3'd1;
    localparam logic [ADDR_W-1:0] A_FALL = 3'd2;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd3;
    localparam logic [ADDR_W-1:0] A_PEND = 3'd4;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd5;

    typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/thermal_regfile.sv
// Register file of the monitor: holds control, level and enable settings,
// decodes clear pulses and muxes read data. Assumes single-cycle write strobes;
// pending flags live in the level cells and only come in for read-back.
module thermal_regfile
    import thermal_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [WORD_W-1:0]             wdata,
    input  logic [WORD_W-1:0]             pend_word,
    output logic [WORD_W-1:0]             rdata,
    output logic                          core_en,
    output logic                          trip_en,
    output logic [MUX_W-1:0]              mux_sel,
    output logic [LEVELS-1:0][CODE_W-1:0] rise_thr,
    output logic [LEVELS-1:0][CODE_W-1:0] fall_thr,
    output logic [CODE_W-1:0]             hw_thr,
    output logic [LEVELS-1:0]             rise_en,
    output logic [LEVELS-1:0]             fall_en,
    output logic [LEVELS-1:0]             clr_rise,
    output logic [LEVELS-1:0]             clr_fall
);
    localparam int FALL_W = LEVELS * CODE_W;

    logic [WORD_W-1:0] rise_q;
    logic [FALL_W-1:0] fall_q;
    logic [WORD_W-1:0] ctrl_rd;
    logic [WORD_W-1:0] ien_rd;

    // Control and threshold storage, written by full-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_en <= 1'b0;
            trip_en <= 1'b0;
            mux_sel <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
        end else if (wr) begin
            if (addr == A_CTRL) begin
                core_en <= wdata[CORE_BIT];
                trip_en <= wdata[TRIP_EN_BIT];
                mux_sel <= wdata[MUX_LSB +: MUX_W];
            end
            if (addr == A_RISE) rise_q <= wdata;
            if (addr == A_FALL) fall_q <= wdata[FALL_W-1:0];
        end
    end

    generate
        for (genvar n = 0; n < LEVELS; n++) begin : g_lvl
            localparam int RP = n * STRIDE;
            localparam int FP = FALL_BASE + n * STRIDE;

            // Per-level enable bits at the strided positions.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rise_en[n] <= 1'b0;
                    fall_en[n] <= 1'b0;
                end else if (wr && addr == A_IEN) begin
                    rise_en[n] <= wdata[RP];
                    fall_en[n] <= wdata[FP];
                end
            end

            assign rise_thr[n] = rise_q[n*CODE_W +: CODE_W];
            assign fall_thr[n] = fall_q[n*CODE_W +: CODE_W];
            assign clr_rise[n] = wr && (addr == A_CLR) && wdata[RP];
            assign clr_fall[n] = wr && (addr == A_CLR) && wdata[FP];
        end
    endgenerate

    assign hw_thr = rise_q[HW_BYTE*CODE_W +: CODE_W];

    // Assemble the read images of control and enable registers.
    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[CORE_BIT] = core_en;
        ctrl_rd[TRIP_EN_BIT] = trip_en;
        ctrl_rd[MUX_LSB +: MUX_W] = mux_sel;
        ien_rd = '0;
        for (int i = 0; i < LEVELS; i++) begin
            ien_rd[i*STRIDE] = rise_en[i];
            ien_rd[FALL_BASE + i*STRIDE] = fall_en[i];
        end
    end

    // Read-data multiplexer; the clear register and holes read zero.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata = ctrl_rd;
            A_RISE:  rdata = rise_q;
            A_FALL:  rdata = {{(WORD_W-FALL_W){1'b0}}, fall_q};
            A_IEN:   rdata = ien_rd;
            A_PEND:  rdata = pend_word;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/thermal_level.sv
// One interrupt level: rising and falling pending flags plus an arm bit.
// Assumes sample_ok already combines core enable and valid; a sample that
// sets a flag beats a clear pulse in the same cycle.
module thermal_level
    import thermal_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sample_ok,
    input  code_t code,
    input  code_t rise_thr,
    input  code_t fall_thr,
    input  logic  clr_rise,
    input  logic  clr_fall,
    output logic  rise_pend,
    output logic  fall_pend
);
    logic armed;
    logic rise_hit;
    logic fall_hit;

    assign rise_hit = sample_ok && (code >= rise_thr);
    assign fall_hit = sample_ok && armed && (code < fall_thr);

    // Flags set on events, clear on write-one; the fall event disarms first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            rise_pend <= 1'b0;
            fall_pend <= 1'b0;
        end else begin
            armed     <= fall_hit ? 1'b0 : (rise_hit ? 1'b1 : armed);
            rise_pend <= rise_hit | (rise_pend & ~clr_rise);
            fall_pend <= fall_hit | (fall_pend & ~clr_fall);
        end
    end
endmodule

// File: rtl/thermal_trip.sv
// Sticky hardware thermal trip. Assumes sample_ok combines core enable and
// valid; once set, only reset releases it.
module thermal_trip
    import thermal_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sample_ok,
    input  logic  trip_en,
    input  code_t code,
    input  code_t hw_thr,
    output logic  trip
);
    // Latch the trip on the first qualifying sample.
    always_ff @(posedge clk) begin
        if (!rst_n) trip <= 1'b0;
        else if (sample_ok && trip_en && (code >= hw_thr)) trip <= 1'b1;
    end
endmodule

// File: rtl/thermal_irq_monitor.sv
// Top of the thermal threshold interrupt monitor. Ties the register file,
// one cell per level and the trip latch together and forms the interrupt.
// Assumes samples and register accesses are synchronous to clk.
module thermal_irq_monitor
    import thermal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_valid,
    input  logic [7:0]        temp_code,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              trip_out,
    output logic [3:0]        sensor_sel
);
    logic                          core_en;
    logic                          trip_en;
    logic                          sample_ok;
    logic [LEVELS-1:0][CODE_W-1:0] rise_thr;
    logic [LEVELS-1:0][CODE_W-1:0] fall_thr;
    logic [CODE_W-1:0]             hw_thr;
    logic [LEVELS-1:0]             rise_en;
    logic [LEVELS-1:0]             fall_en;
    logic [LEVELS-1:0]             clr_rise;
    logic [LEVELS-1:0]             clr_fall;
    logic [LEVELS-1:0]             rise_pend;
    logic [LEVELS-1:0]             fall_pend;
    logic [WORD_W-1:0]             pend_word;

    assign sample_ok = core_en && temp_valid;

    thermal_regfile i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .pend_word (pend_word),
        .rdata     (reg_rdata),
        .core_en   (core_en),
        .trip_en   (trip_en),
        .mux_sel   (sensor_sel),
        .rise_thr  (rise_thr),
        .fall_thr  (fall_thr),
        .hw_thr    (hw_thr),
        .rise_en   (rise_en),
        .fall_en   (fall_en),
        .clr_rise  (clr_rise),
        .clr_fall  (clr_fall)
    );

    generate
        for (genvar n = 0; n < LEVELS; n++) begin : g_level
            thermal_level i_level (
                .clk       (clk),
                .rst_n     (rst_n),
                .sample_ok (sample_ok),
                .code      (temp_code),
                .rise_thr  (rise_thr[n]),
                .fall_thr  (fall_thr[n]),
                .clr_rise  (clr_rise[n]),
                .clr_fall  (clr_fall[n]),
                .rise_pend (rise_pend[n]),
                .fall_pend (fall_pend[n])
            );
        end
    endgenerate

    thermal_trip i_trip (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_ok (sample_ok),
        .trip_en   (trip_en),
        .code      (temp_code),
        .hw_thr    (hw_thr),
        .trip      (trip_out)
    );

    // Place the level flags at their strided bit positions.
    always_comb begin
        pend_word = '0;
        for (int i = 0; i < LEVELS; i++) begin
            pend_word[i*STRIDE] = rise_pend[i];
            pend_word[FALL_BASE + i*STRIDE] = fall_pend[i];
        end
    end

    // Interrupt: any flag that is pending and enabled.
    assign irq = |{rise_pend & rise_en, fall_pend & fall_en};
endmodule

// File: rtl/thermal_irq_monitor_chk.sv
// Property checker for the thermal monitor, bound to the top. Assumes
// known inputs while strobes are high.
module thermal_irq_monitor_chk
    import thermal_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              temp_valid,
    input logic [7:0]        temp_code,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              irq,
    input logic              trip_out,
    input logic              core_en,
    input logic              trip_en,
    input logic [7:0]        hw_thr,
    input logic [7:0]        thr0,
    input logic [2:0]        rise_en,
    input logic [2:0]        fall_en,
    input logic [31:0]       pend_word
);
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && temp_valid && temp_code >= thr0) |=> pend_word[0]); // R5

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(core_en && temp_valid) && !(reg_wr && reg_addr == A_CLR)) |=> $stable(pend_word)); // R7

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CLR && reg_wdata[0] && !(core_en && temp_valid && temp_code >= thr0))
        |=> !pend_word[0]); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_en == '0 && fall_en == '0) |-> !irq); // R10

    AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        trip_out |=> trip_out); // R11

    AST_TRIP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_out) |-> $past(core_en && trip_en && temp_valid && temp_code >= hw_thr)); // R11
endmodule

bind thermal_irq_monitor thermal_irq_monitor_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .temp_valid (temp_valid),
    .temp_code  (temp_code),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .irq        (irq),
    .trip_out   (trip_out),
    .core_en    (core_en),
    .trip_en    (trip_en),
    .hw_thr     (hw_thr),
    .thr0       (rise_thr[0]),
    .rise_en    (rise_en),
    .fall_en    (fall_en),
    .pend_word  (pend_word)
);

// File: tb/test_thermal_irq_monitor.sv
// Directed bench for the thermal monitor: one task per scenario.
module test_thermal_irq_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        temp_valid = 1'b0;
    logic [7:0]  temp_code = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        trip_out;
    logic [3:0]  sensor_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    thermal_irq_monitor i_thermal_irq_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .temp_valid (temp_valid),
        .temp_code  (temp_code),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq),
        .trip_out   (trip_out),
        .sensor_sel (sensor_sel)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic samp(input logic [7:0] c);
        temp_valid = 1'b1; temp_code = c;
        @(posedge clk); @(negedge clk);
        temp_valid = 1'b0;
    endtask

    task automatic t_reset;
        for (int a = 0; a < 6; a++) rd_chk(3'(a), 32'h0, "R1 reg after reset");
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 trip", {31'b0, trip_out}, 0);
        chk("R1 sensor_sel", {28'b0, sensor_sel}, 0);
    endtask

    task automatic t_regmap;
        wr(3'd0, 32'hFFFF_FFFF);
        rd_chk(3'd0, 32'h00F0_1001, "R2 ctrl readback");
        chk("R2 sensor_sel", {28'b0, sensor_sel}, 32'hF);
        wr(3'd1, 32'h6E69_5F1E);
        rd_chk(3'd1, 32'h6E69_5F1E, "R3 rise word");
        wr(3'd2, 32'hAABB_CCDD);
        rd_chk(3'd2, 32'h00BB_CCDD, "R3 fall word");
        wr(3'd3, 32'hFFFF_FFFF);
        rd_chk(3'd3, 32'h0111_0111, "R4 enable word");
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h0);
        wr(3'd4, 32'hFFFF_FFFF);
        rd_chk(3'd4, 32'h0, "R9 pending write ignored");
    endtask

    task automatic t_core_off;
        wr(3'd0, 32'h0000_1000);
        wr(3'd1, 32'h0101_0101);
        samp(8'h80);
        rd_chk(3'd4, 32'h0, "R7 core off pending");
        chk("R7 core off trip", {31'b0, trip_out}, 0);
        wr(3'd0, 32'h0000_1001);
        temp_code = 8'h80;
        @(posedge clk); @(negedge clk);
        rd_chk(3'd4, 32'h0, "R7 valid low pending");
        chk("R7 valid low trip", {31'b0, trip_out}, 0);
    endtask

    task automatic t_rise;
        wr(3'd0, 32'h0060_0001);
        chk("R2 mux value", {28'b0, sensor_sel}, 32'h6);
        wr(3'd1, 32'h6E69_5F1E);
        wr(3'd3, 32'h0000_0110);
        samp(8'd94);
        rd_chk(3'd4, 32'h001, "R5 only level0 at 94");
        chk("R10 masked level0", {31'b0, irq}, 0);
        samp(8'd95);
        rd_chk(3'd4, 32'h011, "R5 level1 at equality");
        chk("R10 irq level1", {31'b0, irq}, 1);
        samp(8'd120);
        rd_chk(3'd4, 32'h111, "R5 level2 at 120");
        chk("R11 trip needs trip enable", {31'b0, trip_out}, 0);
    endtask

    task automatic t_clear;
        wr(3'd5, 32'h010);
        rd_chk(3'd4, 32'h101, "R8 clear level1");
        chk("R10 irq from level2", {31'b0, irq}, 1);
        wr(3'd5, 32'h0);
        rd_chk(3'd4, 32'h101, "R8 zero write no effect");
        rd_chk(3'd5, 32'h0, "R8 clear reads zero");
        wr(3'd5, 32'h100);
        rd_chk(3'd4, 32'h001, "R8 clear level2");
        chk("R10 irq drops", {31'b0, irq}, 0);
        reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h001;
        temp_valid = 1'b1; temp_code = 8'd50;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0; temp_valid = 1'b0;
        rd_chk(3'd4, 32'h001, "R8 set beats clear");
    endtask

    task automatic t_fall;
        wr(3'd2, 32'h0000_0028);
        wr(3'd5, 32'h0111_0111);
        wr(3'd3, 32'h0001_0000);
        samp(8'd39);
        rd_chk(3'd4, 32'h0001_0001, "R6 fall while armed");
        chk("R10 irq falling enabled", {31'b0, irq}, 1);
        wr(3'd5, 32'h0111_0111);
        samp(8'd20);
        rd_chk(3'd4, 32'h0, "R6 disarmed no fall");
        samp(8'd35);
        rd_chk(3'd4, 32'h0000_0001, "R6 rearm without fall");
        samp(8'd20);
        rd_chk(3'd4, 32'h0001_0001, "R6 fall after rearm");
        wr(3'd5, 32'h0000_0001);
        chk("R10 irq falling only", {31'b0, irq}, 1);
    endtask

    task automatic t_trip;
        wr(3'd3, 32'h0);
        wr(3'd0, 32'h0000_1001);
        samp(8'd109);
        chk("R11 below hw level", {31'b0, trip_out}, 0);
        samp(8'd110);
        chk("R11 trip at hw level", {31'b0, trip_out}, 1);
        chk("R11 irq independent", {31'b0, irq}, 0);
        wr(3'd0, 32'h0);
        samp(8'd10);
        wr(3'd5, 32'h0111_0111);
        chk("R11 trip sticky", {31'b0, trip_out}, 1);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 trip released by reset", {31'b0, trip_out}, 0);
        rst_n = 1'b1;
        rd_chk(3'd1, 32'h0, "R1 rise word after reset");
        rd_chk(3'd4, 32'h0, "R1 pending after reset");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_core_off();
        t_rise();
        t_clear();
        t_fall();
        t_trip();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule